// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer with Task Tags

This block is a small, fully associative address translation buffer that software fills and empties. Each lookup presents a 32-bit virtual address, an 8-bit task tag, an access kind (read, write or execute) and a privilege flag. One clock later the block answers with a physical address or a fault cause. Each entry maps one page, and the page size is chosen per entry from 4 KB up to 16 MB in steps of four. Every entry carries its own task tag, an optional match-any-task flag, and execute, write and privileged-only permission bits.

The block never walks page tables. A miss is reported to software like any other fault, and software then rewrites an entry through the write port. The first fault is held in a latch, with its cause code and faulting address, until software releases it. A small state machine runs that latch. It has two states: `EXC_IDLE` (nothing pending) and `EXC_HELD` (a fault is captured). Its transitions are named as follows:
- CAPTURE: `EXC_IDLE` to `EXC_HELD`, taken on any faulting lookup.
- HOLD: `EXC_HELD` to `EXC_HELD` when there is no release.
- RECAPTURE: `EXC_HELD` to `EXC_HELD` when a release and a new fault arrive in the same cycle.
- RELEASE: `EXC_HELD` to `EXC_IDLE` on a release with no new fault.

A release seen in `EXC_IDLE` has no effect.

Top module: `vpt_tlb`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_ok` and `exc_pending` are 0, and every entry is invalid, so any lookup misses.
- R2: A lookup sampled with `lk_valid` at a clock edge is answered at that same edge, so the answer is visible for the following cycle. `rsp_valid` is 1 only in that cycle. With no lookup, `rsp_valid` and `rsp_ok` are 0.
- R3: An entry hits when it is valid and the VA equals `{vpn,12'b0}` in every bit above the page offset. The offset is 12+2*size bits wide, for size codes 0..6 (4K, 16K, 64K, 256K, 1M, 4M, 16M). Size code 7 never hits. On success, `rsp_pa` takes the bits of `{ppn,12'b0}` above the offset and the VA bits inside the offset.
- R4: A hit requires the entry's task tag to equal `lk_tid`, unless the entry's global bit is set. A global entry matches any tag.
- R5: When no entry hits, the response carries cause 1 (miss), with `rsp_ok`=0 and `rsp_pa`=0. The cause codes are 0 none, 1 miss, 2 privilege, 3 access.
- R6: A hit on a privileged-only entry while `lk_super`=0 gives cause 2.
- R7: The access kinds are encoded 0 read, 1 write, 2 execute, and 3 acts as a read. A write to an entry with w=0, or an execute from an entry with x=0, gives cause 3. Reads are never refused by the w or x bits, and privileged mode does not bypass w or x.
- R8: When both a privilege and an access violation apply, cause 2 is reported.
- R9: When several entries hit, the lowest-index entry supplies the translation and permissions, and `rsp_multi` is 1. It is 0 otherwise.
- R10: The first faulting lookup sets `exc_pending` and latches `exc_cause` and `exc_va` in the same cycle that its response appears. Later faults do not overwrite them while they are held. `exc_clear` releases the latch, but a fault arriving in the same cycle as `exc_clear` is latched instead. `exc_clear` while nothing is pending has no effect.
- R11: An entry write at a clock edge is seen by lookups at later edges, not by a lookup at the same edge. Writing `wr_valid`=0 invalidates the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_tid | input | 8 | Task tag |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| lk_super | input | 1 | Requester is privileged |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_cause | output | 2 | 0 none, 1 miss, 2 privilege, 3 access |
| rsp_pa | output | 32 | Physical address, 0 on fault |
| rsp_multi | output | 1 | More than one entry hit |
| exc_pending | output | 1 | Latched fault present |
| exc_cause | output | 2 | Latched fault cause |
| exc_va | output | 32 | Latched faulting address |
| exc_clear | input | 1 | Release the latched fault |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index |
| wr_valid | input | 1 | Entry valid bit (0 invalidates) |
| wr_vpn | input | 20 | Virtual page number |
| wr_ppn | input | 20 | Physical page number |
| wr_size | input | 3 | Page size code |
| wr_tid | input | 8 | Entry task tag |
| wr_global | input | 1 | Entry matches any task |
| wr_x | input | 1 | Execute allowed |
| wr_w | input | 1 | Write allowed |
| wr_s | input | 1 | Privileged-only |

## Verification
The bench places the physical page number so that its low bits differ under the offset mask. A design that failed to clear those bits would therefore return a visibly wrong address for 16 KB pages. It also probes the address just past a page's end, and it checks that a size-7 entry stays unmatched. An overlapping pair of entries shows whether the priority encoder picks the lowest index. A combined privilege-plus-write violation shows whether the fault priority is reversed. In the latch tests, back-to-back faults, a release arriving together with a new fault, and a write landing in the same cycle as a lookup together expose a latch that overwrites, a latch that drops the new fault, and a write port that bypasses into the lookup.

// File: rtl/vpt_tlb_pkg.sv
package vpt_tlb_pkg;
    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 12;
    localparam int PN_W     = VA_W - PG_SHIFT;
    localparam int TID_W    = 8;
    localparam int SIZE_W   = 3;
    localparam logic [SIZE_W-1:0] SIZE_RSVD = 3'd7;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_MISS = 2'd1,
        CAUSE_PRIV = 2'd2,
        CAUSE_PERM = 2'd3
    } cause_e;

    typedef enum logic {
        EXC_IDLE = 1'b0,
        EXC_HELD = 1'b1
    } exc_state_e;

    typedef struct packed {
        logic              valid;
        logic [PN_W-1:0]   vpn;
        logic [PN_W-1:0]   ppn;
        logic [SIZE_W-1:0] size;
        logic [TID_W-1:0]  tid;
        logic              global_en;
        logic              x;
        logic              w;
        logic              s;
    } tlb_entry_t;

    function automatic logic [VA_W-1:0] off_mask(input logic [SIZE_W-1:0] sz);
        int sh;
        sh = PG_SHIFT + 2 * int'(sz);
        return ~({VA_W{1'b1}} << sh);
    endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import vpt_tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    output tlb_entry_t       entries [N]
);
    tlb_entry_t ent_q [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                ent_q[g] <= wr_entry;
        end
    end

    assign entries = ent_q;

    // R11: a write lands in the addressed slot on the next edge
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_q[$past(wr_idx)] == $past(wr_entry));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import vpt_tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  tlb_entry_t        entries [N],
    input  logic [VA_W-1:0]   va,
    input  logic [TID_W-1:0]  tid,
    output logic [N-1:0]      hit_vec,
    output logic              hit_any,
    output logic              multi,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [PN_W-1:0]   sel_ppn,
    output logic [VA_W-1:0]   sel_mask,
    output logic              sel_x,
    output logic              sel_w,
    output logic              sel_s
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [VA_W-1:0] base;
        logic [VA_W-1:0] msk;
        logic            addr_eq;
        logic            tid_ok;
        always_comb begin
            base    = {entries[g].vpn, {PG_SHIFT{1'b0}}};
            msk     = off_mask(entries[g].size);
            addr_eq = ((va ^ base) & ~msk) == '0;
            tid_ok  = entries[g].global_en || (entries[g].tid == tid);
            hit_vec[g] = entries[g].valid && (entries[g].size != SIZE_RSVD)
                         && addr_eq && tid_ok;
        end
    end

    always_comb begin
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel_idx = IDX_W'(i);
        end
    end

    assign hit_any  = |hit_vec;
    assign multi    = $countones(hit_vec) > 1;
    assign sel_ppn  = entries[sel_idx].ppn;
    assign sel_mask = off_mask(entries[sel_idx].size);
    assign sel_x    = entries[sel_idx].x;
    assign sel_w    = entries[sel_idx].w;
    assign sel_s    = entries[sel_idx].s;
endmodule

// File: rtl/tlb_fault_ctrl.sv
module tlb_fault_ctrl
    import vpt_tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fault_valid,
    input  cause_e          fault_cause,
    input  logic [VA_W-1:0] fault_va,
    input  logic            clear,
    output logic            pending,
    output cause_e          cause,
    output logic [VA_W-1:0] va
);
    exc_state_e state_q, state_d;
    logic       capture;
    cause_e     cause_q;
    logic [VA_W-1:0] va_q;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            EXC_IDLE: begin
                if (fault_valid) begin
                    state_d = EXC_HELD;          // CAPTURE
                    capture = 1'b1;
                end
            end
            EXC_HELD: begin
                if (clear && fault_valid) begin
                    state_d = EXC_HELD;          // RECAPTURE
                    capture = 1'b1;
                end else if (clear) begin
                    state_d = EXC_IDLE;          // RELEASE
                end
            end
            default: state_d = EXC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EXC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
            va_q    <= '0;
        end else if (capture) begin
            cause_q <= fault_cause;
            va_q    <= fault_va;
        end else if (state_d == EXC_IDLE) begin
            cause_q <= CAUSE_NONE;
            va_q    <= '0;
        end
    end

    assign pending = (state_q == EXC_HELD);
    assign cause   = cause_q;
    assign va      = va_q;

    // R10: a held fault keeps its record until released
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EXC_HELD && !clear) |=>
            (state_q == EXC_HELD && $stable(cause_q) && $stable(va_q)));
    // R10: release with nothing new returns to idle
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EXC_HELD && clear && !fault_valid) |=> state_q == EXC_IDLE);
endmodule

// File: rtl/vpt_tlb.sv
module vpt_tlb
    import vpt_tlb_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [31:0]      lk_va,
    input  logic [7:0]       lk_tid,
    input  logic [1:0]       lk_kind,
    input  logic             lk_super,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic [1:0]       rsp_cause,
    output logic [31:0]      rsp_pa,
    output logic             rsp_multi,
    output logic             exc_pending,
    output logic [1:0]       exc_cause,
    output logic [31:0]      exc_va,
    input  logic             exc_clear,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [19:0]      wr_vpn,
    input  logic [19:0]      wr_ppn,
    input  logic [2:0]       wr_size,
    input  logic [7:0]       wr_tid,
    input  logic             wr_global,
    input  logic             wr_x,
    input  logic             wr_w,
    input  logic             wr_s
);
    tlb_entry_t            wr_entry;
    tlb_entry_t            entries [N_ENTRIES];
    logic [N_ENTRIES-1:0]  m_hit_vec;
    logic                  m_hit, m_multi;
    logic [IDX_W-1:0]      m_sel_idx;
    logic [PN_W-1:0]       m_ppn;
    logic [VA_W-1:0]       m_mask;
    logic                  m_x, m_w, m_s;
    cause_e                cause_c;
    logic [VA_W-1:0]       pa_c;
    acc_e                  kind;
    cause_e                exc_cause_e;

    assign wr_entry = '{valid: wr_valid, vpn: wr_vpn, ppn: wr_ppn, size: wr_size,
                        tid: wr_tid, global_en: wr_global, x: wr_x, w: wr_w, s: wr_s};

    tlb_entry_store #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_entry(wr_entry), .entries(entries));

    tlb_match #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_match (
        .entries(entries), .va(lk_va), .tid(lk_tid), .hit_vec(m_hit_vec),
        .hit_any(m_hit), .multi(m_multi), .sel_idx(m_sel_idx), .sel_ppn(m_ppn),
        .sel_mask(m_mask), .sel_x(m_x), .sel_w(m_w), .sel_s(m_s));

    assign kind = acc_e'(lk_kind);

    always_comb begin
        if (!m_hit)
            cause_c = CAUSE_MISS;
        else if (m_s && !lk_super)
            cause_c = CAUSE_PRIV;
        else if ((kind == ACC_WRITE && !m_w) || (kind == ACC_EXEC && !m_x))
            cause_c = CAUSE_PERM;
        else
            cause_c = CAUSE_NONE;
        pa_c = ({m_ppn, {PG_SHIFT{1'b0}}} & ~m_mask) | (lk_va & m_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_pa    <= '0;
            rsp_multi <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_ok    <= lk_valid && (cause_c == CAUSE_NONE);
            rsp_cause <= lk_valid ? cause_c : CAUSE_NONE;
            rsp_pa    <= (lk_valid && cause_c == CAUSE_NONE) ? pa_c : '0;
            rsp_multi <= lk_valid && m_multi;
        end
    end

    tlb_fault_ctrl u_fault (
        .clk(clk), .rst_n(rst_n),
        .fault_valid(lk_valid && cause_c != CAUSE_NONE),
        .fault_cause(cause_c), .fault_va(lk_va), .clear(exc_clear),
        .pending(exc_pending), .cause(exc_cause_e), .va(exc_va));

    assign exc_cause = exc_cause_e;

    // R2: a response only follows a lookup
    a_r2_rsp_follows_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid));
    // R5: success and a fault cause never coexist
    a_r5_ok_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (rsp_valid && rsp_cause == CAUSE_NONE));
    // R9: multi-hit is never reported alongside a miss
    a_r9_multi_not_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multi |-> (rsp_valid && rsp_cause != CAUSE_MISS));
    // R9: selected entry is the lowest hitting index
    a_r9_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
        m_hit |-> (m_hit_vec[m_sel_idx] &&
                   ((m_hit_vec & ((N_ENTRIES'(1) << m_sel_idx) - N_ENTRIES'(1))) == '0)));
    // R10: any faulting response leaves a pending fault
    a_r10_fault_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != CAUSE_NONE) |-> exc_pending);
endmodule

// File: tb/vpt_tlb_test.sv
module vpt_tlb_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_tid = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_super = 1'b0;
    logic        rsp_valid, rsp_ok, rsp_multi, exc_pending;
    logic [1:0]  rsp_cause, exc_cause;
    logic [31:0] rsp_pa, exc_va;
    logic        exc_clear = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic [2:0]  wr_size = '0;
    logic [7:0]  wr_tid = '0;
    logic        wr_global = 1'b0, wr_x = 1'b0, wr_w = 1'b0, wr_s = 1'b0;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpt_tlb uut (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  tid;
        logic [1:0]  kind;
        logic        sup;
        logic [1:0]  cause;
        logic [31:0] pa;
        logic        multi;
        logic [4:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{32'h1234_5678, 8'd5,   2'd0, 1'b0, 2'd0, 32'h00AB_C678, 1'b0, 5'd3},  // R3 4K
        '{32'h1234_5678, 8'd9,   2'd0, 1'b0, 2'd0, 32'h00DE_F678, 1'b0, 5'd4},  // R4 tag picks entry
        '{32'h1234_5678, 8'd4,   2'd0, 1'b0, 2'd1, 32'h0,         1'b0, 5'd5},  // R5 tag mismatch miss
        '{32'h4000_ABCD, 8'd200, 2'd2, 1'b0, 2'd0, 32'h8000_ABCD, 1'b0, 5'd4},  // R4 global
        '{32'h4000_ABCD, 8'd7,   2'd1, 1'b0, 2'd3, 32'h0,         1'b0, 5'd7},  // R7 write w=0
        '{32'hC0FF_EE00, 8'd3,   2'd0, 1'b0, 2'd2, 32'h0,         1'b0, 5'd6},  // R6 user on priv page
        '{32'hC0FF_EE00, 8'd3,   2'd1, 1'b1, 2'd0, 32'h01FF_EE00, 1'b0, 5'd3},  // R3 16M
        '{32'hC0FF_EE00, 8'd3,   2'd2, 1'b1, 2'd3, 32'h0,         1'b0, 5'd7},  // R7 priv no bypass
        '{32'h2001_2345, 8'd5,   2'd1, 1'b0, 2'd2, 32'h0,         1'b0, 5'd8},  // R8 priority
        '{32'h2001_2345, 8'd5,   2'd0, 1'b1, 2'd0, 32'h3001_2345, 1'b0, 5'd3},  // R3 1M
        '{32'h5000_0ABC, 8'd5,   2'd2, 1'b0, 2'd0, 32'h6000_4ABC, 1'b0, 5'd3},  // R3 16K ppn mask
        '{32'h5000_4000, 8'd5,   2'd0, 1'b0, 2'd1, 32'h0,         1'b0, 5'd3},  // R3 past page end
        '{32'h4000_1234, 8'd7,   2'd0, 1'b0, 2'd0, 32'h8000_1234, 1'b1, 5'd9},  // R9 multi-hit
        '{32'h7000_0123, 8'd1,   2'd0, 1'b0, 2'd1, 32'h0,         1'b0, 5'd3},  // R3 size code 7
        '{32'h4000_ABCD, 8'd1,   2'd3, 1'b0, 2'd0, 32'h8000_ABCD, 1'b0, 5'd7}   // R7 kind 3 reads
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_entry(input int idx, input bit v, input logic [19:0] vpn,
                               input logic [19:0] ppn, input logic [2:0] sz,
                               input logic [7:0] tid, input bit g, input bit x,
                               input bit w, input bit s);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_valid = v; wr_vpn = vpn; wr_ppn = ppn;
        wr_size = sz; wr_tid = tid; wr_global = g; wr_x = x; wr_w = w; wr_s = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_exc();
        @(negedge clk);
        exc_clear = 1'b1;
        @(negedge clk);
        exc_clear = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [7:0] tid,
                          input logic [1:0] kind, input bit sup);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_tid = tid; lk_kind = kind; lk_super = sup;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rsp_valid == 0 && rsp_ok == 0, "R1", "rsp after reset", {30'b0, rsp_valid, rsp_ok}, 0);
        check(exc_pending == 0, "R1", "exc_pending after reset", 32'(exc_pending), 0);
        lookup(32'h1234_5678, 8'd5, 2'd0, 1'b0);
        check(rsp_cause == 2'd1, "R1", "empty buffer misses", 32'(rsp_cause), 1);
        clear_exc();
        // R2 no lookup, no response
        check(rsp_valid == 0 && rsp_ok == 0, "R2", "idle cycle", {30'b0, rsp_valid, rsp_ok}, 0);

        write_entry(0, 1, 20'h12345, 20'h00ABC, 3'd0, 8'd5,   0, 0, 1, 0);
        write_entry(1, 1, 20'h40000, 20'h80000, 3'd2, 8'd7,   1, 1, 0, 0);
        write_entry(2, 1, 20'hC0000, 20'h01000, 3'd6, 8'd3,   0, 0, 1, 1);
        write_entry(3, 1, 20'h12345, 20'h00DEF, 3'd0, 8'd9,   0, 1, 1, 0);
        write_entry(4, 1, 20'h20000, 20'h30000, 3'd4, 8'd5,   0, 0, 0, 1);
        write_entry(5, 1, 20'h50000, 20'h60007, 3'd1, 8'd5,   0, 1, 1, 0);
        write_entry(6, 1, 20'h40001, 20'h90000, 3'd0, 8'd7,   0, 1, 1, 0);
        write_entry(7, 1, 20'h70000, 20'h00000, 3'd7, 8'd0,   1, 1, 1, 0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VT[i].req);
            lookup(VT[i].va, VT[i].tid, VT[i].kind, VT[i].sup);
            check(rsp_valid == 1, rq, $sformatf("v%0d rsp_valid", i), 32'(rsp_valid), 1);
            check(rsp_cause == VT[i].cause, rq, $sformatf("v%0d cause", i), 32'(rsp_cause), 32'(VT[i].cause));
            check(rsp_ok == (VT[i].cause == 2'd0), rq, $sformatf("v%0d ok", i), 32'(rsp_ok), 32'(VT[i].cause == 2'd0));
            check(rsp_pa == VT[i].pa, rq, $sformatf("v%0d pa", i), rsp_pa, VT[i].pa);
            check(rsp_multi == VT[i].multi, rq, $sformatf("v%0d multi", i), 32'(rsp_multi), 32'(VT[i].multi));
            if (VT[i].cause != 2'd0) begin
                // R10 fault latched with its address
                check(exc_pending && exc_cause == VT[i].cause && exc_va == VT[i].va, "R10",
                      $sformatf("v%0d latch va", i), exc_va, VT[i].va);
                clear_exc();
                check(!exc_pending, "R10", "released", 32'(exc_pending), 0);
            end
        end

        // R10 back-to-back faults: first one kept
        @(negedge clk);
        lk_valid = 1'b1; lk_va = 32'hDEAD_0000; lk_tid = 8'd1; lk_kind = 2'd0; lk_super = 1'b0;
        @(negedge clk);
        lk_va = 32'hC0FF_EE00; lk_tid = 8'd3;
        @(negedge clk);
        lk_valid = 1'b0;
        check(exc_pending && exc_cause == 2'd1 && exc_va == 32'hDEAD_0000, "R10",
              "first fault kept", exc_va, 32'hDEAD_0000);
        // R10 release with simultaneous new fault latches the new one
        exc_clear = 1'b1; lk_valid = 1'b1;
        @(negedge clk);
        exc_clear = 1'b0; lk_valid = 1'b0;
        check(exc_pending && exc_cause == 2'd2 && exc_va == 32'hC0FF_EE00, "R10",
              "recapture on clear", {30'b0, exc_cause}, 2);
        clear_exc();
        check(!exc_pending, "R10", "release", 32'(exc_pending), 0);
        clear_exc();
        check(!exc_pending && exc_cause == 2'd0, "R10", "clear while idle", 32'(exc_pending), 0);

        // R11 write and lookup at the same edge sees old contents
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd8; wr_valid = 1'b1; wr_vpn = 20'hABCDE; wr_ppn = 20'h11111;
        wr_size = 3'd0; wr_tid = 8'd2; wr_global = 1'b0; wr_x = 1'b1; wr_w = 1'b1; wr_s = 1'b0;
        lk_valid = 1'b1; lk_va = 32'hABCD_E123; lk_tid = 8'd2; lk_kind = 2'd1; lk_super = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        check(rsp_cause == 2'd1, "R11", "same-edge lookup uses old entry", 32'(rsp_cause), 1);
        @(negedge clk);
        lk_valid = 1'b0;
        check(rsp_ok && rsp_pa == 32'h1111_1123, "R11", "next lookup sees write", rsp_pa, 32'h1111_1123);
        clear_exc();
        write_entry(8, 0, 20'hABCDE, 20'h11111, 3'd0, 8'd2, 0, 1, 1, 0);
        lookup(32'hABCD_E123, 8'd2, 2'd0, 1'b0);
        check(rsp_cause == 2'd1, "R11", "invalidated entry misses", 32'(rsp_cause), 1);
        clear_exc();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule